// File: doc/BRIEF.md
# Fail-Safe Output Controller

This block stands between a supervisory processor and a bank of critical control outputs. The processor supplies a setpoint for every output, a ready flag and a periodic heartbeat pulse. The block drives those setpoints onto the output bus only while every health condition is good. At all other times each output holds a fixed safe constant that is chosen per output through a parameter. It comes out of reset in the safe mode, so the outputs are safe from power-on.

Four failure causes are tracked. The first is the processor withdrawing its ready flag. The second is an emergency-stop input, which is latched and is also latched when its module reports a read error. The third is a built-in heartbeat watchdog that counts loop iterations since the last heartbeat. The fourth is an error flag from the control-input module. The control loop advances one iteration on each clock cycle where `loop_tick` is high. On that tick the controller evaluates every cause together and picks the mode for the next iteration.

A maintenance input can mask the watchdog cause, but the mask is only picked up while the controller is in the safe mode. A status vector reports every cause, and a mode bit reports whether the processor setpoints are live.

Top module: `failsafe_outctl`

## Requirements
- R1: After reset, `run_mode` is 0, `out_bus` equals the `SAFE_VEC` parameter, and the emergency latch is clear.
- R2: While `run_mode` is 0, `out_bus` equals `SAFE_VEC` regardless of `cmd_setpoint`. While `run_mode` is 1, `out_bus` equals the `cmd_setpoint` value sampled at the last loop tick.
- R3: `run_mode` and `out_bus` change only on clock edges where `loop_tick` is 1. Setpoint changes between ticks do not reach `out_bus`.
- R4: If any bit of `fault_status` is 1 at a loop tick while `run_mode` is 1, then `run_mode` is 0 and `out_bus` is `SAFE_VEC` after that tick.
- R5: `run_mode` rises only at a loop tick where all four `fault_status` bits are 0. A tick that sees any fault leaves the controller in safe mode.
- R6: `fault_status[0]` is 1 exactly while `cpu_ready` is 0.
- R7: `fault_status[1]` (emergency latch) becomes 1 on the clock edge after `estop_in` or `estop_rd_err` is 1. This holds even for a single-cycle pulse between ticks. It stays 1 until cleared as in R8.
- R8: The emergency latch clears only on an edge where `estop_ack` is 1 while `estop_in` and `estop_rd_err` are both 0. An acknowledge given while either is 1 has no effect.
- R9: The watchdog counts loop ticks since the last `heartbeat` pulse, and a heartbeat resets the count. `fault_status[2]` is 1 when more than `WDOG_TIMEOUT` ticks have passed. Out of reset the count starts expired, so a heartbeat is needed before the run mode can be entered.
- R10: `wdog_disable` masks `fault_status[2]`. The mask is sampled only while `run_mode` is 0, so changes of `wdog_disable` during the run mode have no effect.
- R11: `fault_status[3]` is 1 exactly while `inmod_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_tick | input | 1 | One-cycle strobe marking a control-loop iteration |
| cmd_setpoint | input | N_OUT*OUT_W | Processor setpoints, output k in bits [k*OUT_W +: OUT_W] |
| cpu_ready | input | 1 | Processor ready flag |
| heartbeat | input | 1 | Processor heartbeat pulse |
| estop_in | input | 1 | Raw emergency-stop input, active high |
| estop_rd_err | input | 1 | Read error from the emergency-stop input module |
| estop_ack | input | 1 | Acknowledge pulse that clears the emergency latch |
| inmod_err | input | 1 | Control-input module error flag |
| wdog_disable | input | 1 | Maintenance mask for the watchdog cause |
| out_bus | output | N_OUT*OUT_W | Control outputs |
| fault_status | output | 4 | Causes: [0] not ready, [1] emergency, [2] watchdog, [3] inputs invalid |
| run_mode | output | 1 | 1 while processor setpoints drive the outputs |

## Verification
The bench builds the block with two 4-bit outputs, `SAFE_VEC` = 8'hA5 and a watchdog timeout of 3 ticks. With this small timeout, every tick count from 1 to 6 after a heartbeat can be swept, and each expected watchdog bit and mode is computed by arithmetic. Each of the four causes is injected one at a time, both from the run mode and from the safe mode. The emergency latch is driven with single-cycle pulses between ticks and with acknowledges that are both refused and accepted. The masking input is toggled in both modes to show that it is only sampled in the safe mode.

// File: rtl/failsafe_pkg.sv
package failsafe_pkg;
   typedef enum logic {
      FS_SAFE   = 1'b0,
      FS_NORMAL = 1'b1
   } fs_mode_e;

   localparam int unsigned N_CAUSE     = 4;
   localparam int unsigned C_NOT_READY = 0;
   localparam int unsigned C_ESTOP     = 1;
   localparam int unsigned C_WDOG      = 2;
   localparam int unsigned C_INPUTS    = 3;

   typedef logic [N_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/fs_estop_latch.sv
module fs_estop_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_raw,
   input  logic read_err,
   input  logic clear_req,
   output logic tripped
);
   logic trip_cond;
   assign trip_cond = stop_raw | read_err;

   // sampled every clock, not only on loop ticks, so short pulses are caught
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tripped <= 1'b0;
      else if (trip_cond)
         tripped <= 1'b1;
      else if (clear_req)
         tripped <= 1'b0;
   end
endmodule

// File: rtl/fs_heartbeat_wdog.sv
module fs_heartbeat_wdog #(
   parameter int unsigned TIMEOUT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_tick,
   input  logic service,
   input  logic in_safe,
   input  logic mask_req,
   output logic wd_fault
);
   localparam int unsigned CNT_MAX = TIMEOUT + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0] elapsed;
   logic             mask_q;
   logic             expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         elapsed <= CNT_W'(CNT_MAX);
      else if (service)
         elapsed <= '0;
      else if (loop_tick && (elapsed != CNT_W'(CNT_MAX)))
         elapsed <= elapsed + 1'b1;
   end

   // maintenance mask follows its input only in safe mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= 1'b0;
      else if (in_safe)
         mask_q <= mask_req;
   end

   assign expired  = (elapsed > CNT_W'(TIMEOUT));
   assign wd_fault = expired & ~mask_q;
endmodule

// File: rtl/fs_mode_fsm.sv
module fs_mode_fsm
   import failsafe_pkg::*;
#(
   parameter int unsigned N_OUT = 4,
   parameter int unsigned OUT_W = 16,
   parameter logic [N_OUT*OUT_W-1:0] SAFE_VEC = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   loop_tick,
   input  cause_vec_t             causes,
   input  logic [N_OUT*OUT_W-1:0] setpoint,
   output fs_mode_e               mode,
   output logic [N_OUT*OUT_W-1:0] outs
);
   fs_mode_e mode_nxt;

   always_comb begin
      mode_nxt = mode;
      unique case (mode)
         FS_SAFE:   if (causes == '0) mode_nxt = FS_NORMAL;
         FS_NORMAL: if (causes != '0) mode_nxt = FS_SAFE;
         default:   mode_nxt = FS_SAFE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= FS_SAFE;
      else if (loop_tick)
         mode <= mode_nxt;
   end

   for (genvar g = 0; g < N_OUT; g++) begin : g_lane
      logic [OUT_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= SAFE_VEC[g*OUT_W +: OUT_W];
         else if (loop_tick)
            lane_q <= (mode_nxt == FS_NORMAL) ? setpoint[g*OUT_W +: OUT_W]
                                              : SAFE_VEC[g*OUT_W +: OUT_W];
      end
      assign outs[g*OUT_W +: OUT_W] = lane_q;
   end
endmodule

// File: rtl/failsafe_outctl.sv
module failsafe_outctl
   import failsafe_pkg::*;
#(
   parameter int unsigned N_OUT        = 4,
   parameter int unsigned OUT_W        = 16,
   parameter int unsigned WDOG_TIMEOUT = 1000,
   parameter logic [N_OUT*OUT_W-1:0] SAFE_VEC = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   loop_tick,
   input  logic [N_OUT*OUT_W-1:0] cmd_setpoint,
   input  logic                   cpu_ready,
   input  logic                   heartbeat,
   input  logic                   estop_in,
   input  logic                   estop_rd_err,
   input  logic                   estop_ack,
   input  logic                   inmod_err,
   input  logic                   wdog_disable,
   output logic [N_OUT*OUT_W-1:0] out_bus,
   output logic [3:0]             fault_status,
   output logic                   run_mode
);
   localparam int unsigned BUS_W = N_OUT * OUT_W;

   if (N_OUT < 1) begin : g_bad_nout
      $error("failsafe_outctl: N_OUT must be at least 1");
   end
   if (OUT_W < 1) begin : g_bad_outw
      $error("failsafe_outctl: OUT_W must be at least 1");
   end
   if (WDOG_TIMEOUT < 1) begin : g_bad_tmo
      $error("failsafe_outctl: WDOG_TIMEOUT must be at least 1");
   end

   fs_mode_e   mode;
   cause_vec_t causes;
   logic       estop_q;
   logic       wd_fault;
   logic       clear_ok;

   assign clear_ok = estop_ack & ~estop_in & ~estop_rd_err;

   fs_estop_latch u_estop (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_raw  (estop_in),
      .read_err  (estop_rd_err),
      .clear_req (clear_ok),
      .tripped   (estop_q)
   );

   fs_heartbeat_wdog #(.TIMEOUT(WDOG_TIMEOUT)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .loop_tick (loop_tick),
      .service   (heartbeat),
      .in_safe   (mode == FS_SAFE),
      .mask_req  (wdog_disable),
      .wd_fault  (wd_fault)
   );

   always_comb begin
      causes              = '0;
      causes[C_NOT_READY] = ~cpu_ready;
      causes[C_ESTOP]     = estop_q;
      causes[C_WDOG]      = wd_fault;
      causes[C_INPUTS]    = inmod_err;
   end

   fs_mode_fsm #(.N_OUT(N_OUT), .OUT_W(OUT_W), .SAFE_VEC(SAFE_VEC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .loop_tick (loop_tick),
      .causes    (causes),
      .setpoint  (cmd_setpoint),
      .mode      (mode),
      .outs      (out_bus)
   );

   assign fault_status = causes;
   assign run_mode     = (mode == FS_NORMAL);

   logic [BUS_W-1:0] unused_chk;
   assign unused_chk = cmd_setpoint;
endmodule

// File: rtl/failsafe_outctl_chk.sv
module failsafe_outctl_chk #(
   parameter int unsigned BUS_W = 8,
   parameter logic [BUS_W-1:0] SAFE_VEC = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             loop_tick,
   input logic             heartbeat,
   input logic             estop_in,
   input logic             estop_rd_err,
   input logic             estop_ack,
   input logic [3:0]       fault_status,
   input logic             run_mode,
   input logic [BUS_W-1:0] out_bus
);
   p_safe_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_mode |-> out_bus == SAFE_VEC);

   p_only_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_tick |=> $stable(run_mode) && $stable(out_bus));

   p_fault_exits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loop_tick && run_mode && (fault_status != 4'b0) |=> !run_mode);

   p_clean_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      loop_tick && (fault_status != 4'b0) |=> !$rose(run_mode));

   p_estop_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      estop_in || estop_rd_err |=> fault_status[1]);

   p_estop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_status[1] && !estop_ack |=> fault_status[1]);

   p_heartbeat_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      heartbeat |=> !fault_status[2]);
endmodule

bind failsafe_outctl failsafe_outctl_chk #(.BUS_W(BUS_W), .SAFE_VEC(SAFE_VEC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .loop_tick    (loop_tick),
   .heartbeat    (heartbeat),
   .estop_in     (estop_in),
   .estop_rd_err (estop_rd_err),
   .estop_ack    (estop_ack),
   .fault_status (fault_status),
   .run_mode     (run_mode),
   .out_bus      (out_bus)
);

// File: tb/tb_failsafe_outctl.sv
module tb_failsafe_outctl;
   localparam int unsigned N_OUT = 2;
   localparam int unsigned OUT_W = 4;
   localparam int unsigned TMO   = 3;
   localparam logic [7:0]  SAFE  = 8'hA5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       loop_tick = 1'b0;
   logic [7:0] cmd_setpoint = 8'h00;
   logic       cpu_ready = 1'b0;
   logic       heartbeat = 1'b0;
   logic       estop_in = 1'b0;
   logic       estop_rd_err = 1'b0;
   logic       estop_ack = 1'b0;
   logic       inmod_err = 1'b0;
   logic       wdog_disable = 1'b0;
   logic [7:0] out_bus;
   logic [3:0] fault_status;
   logic       run_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   failsafe_outctl #(.N_OUT(N_OUT), .OUT_W(OUT_W), .WDOG_TIMEOUT(TMO), .SAFE_VEC(SAFE)) dut (
      .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick), .cmd_setpoint(cmd_setpoint),
      .cpu_ready(cpu_ready), .heartbeat(heartbeat), .estop_in(estop_in),
      .estop_rd_err(estop_rd_err), .estop_ack(estop_ack), .inmod_err(inmod_err),
      .wdog_disable(wdog_disable), .out_bus(out_bus), .fault_status(fault_status),
      .run_mode(run_mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock with the given strobes, inputs driven and released at falling edges
   task automatic step(input logic t, input logic hb);
      loop_tick = t;
      heartbeat = hb;
      @(posedge clk);
      @(negedge clk);
      loop_tick = 1'b0;
      heartbeat = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   task automatic pulse_estop(input logic rd);
      if (rd) estop_rd_err = 1'b1; else estop_in = 1'b1;
      @(posedge clk);
      @(negedge clk);
      estop_in = 1'b0;
      estop_rd_err = 1'b0;
   endtask

   task automatic ack(input logic raw_high);
      estop_in  = raw_high;
      estop_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      estop_ack = 1'b0;
      estop_in  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired before the bench finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1 / R6 / R9: reset state, ready low, watchdog starts expired
      chk("R1 mode", {31'b0, run_mode}, 32'd0);
      chk("R1 out", {24'b0, out_bus}, {24'b0, SAFE});
      chk("R1 status", {28'b0, fault_status}, 32'b0101);
      rst_n = 1'b1;
      @(negedge clk);
      cmd_setpoint = 8'h3C;
      step(1'b1, 1'b0);
      chk("R5 no entry with faults", {31'b0, run_mode}, 32'd0);
      chk("R2 safe out ignores setpoint", {24'b0, out_bus}, {24'b0, SAFE});
      cpu_ready = 1'b1;
      #1 chk("R6 ready bit", {31'b0, fault_status[0]}, 32'd0);
      step(1'b0, 1'b1);
      chk("R9 heartbeat clears", {28'b0, fault_status}, 32'd0);
      step(1'b1, 1'b1);
      chk("R5 entry", {31'b0, run_mode}, 32'd1);
      chk("R2 live out", {24'b0, out_bus}, 32'h3C);
      cmd_setpoint = 8'h77;
      idle(3);
      chk("R3 hold between ticks", {24'b0, out_bus}, 32'h3C);
      step(1'b1, 1'b1);
      chk("R2 new setpoint", {24'b0, out_bus}, 32'h77);

      // each cause, injected from run mode
      for (int f = 0; f < 4; f++) begin
         case (f)
            0: cpu_ready = 1'b0;
            1: pulse_estop(1'b0);
            2: pulse_estop(1'b1);
            default: inmod_err = 1'b1;
         endcase
         #1;
         if (f == 0) chk("R6 ready lost", {31'b0, fault_status[0]}, 32'd1);
         else if (f == 3) chk("R11 input invalid", {31'b0, fault_status[3]}, 32'd1);
         else chk("R7 estop latched", {31'b0, fault_status[1]}, 32'd1);
         idle(2);
         chk("R3 no exit without tick", {31'b0, run_mode}, 32'd1);
         step(1'b1, 1'b1);
         chk("R4 exit to safe", {31'b0, run_mode}, 32'd0);
         chk("R4 safe outputs", {24'b0, out_bus}, {24'b0, SAFE});
         cmd_setpoint = 8'h10 + 8'(f);
         step(1'b1, 1'b1);
         chk("R5 stay safe", {31'b0, run_mode}, 32'd0);
         chk("R2 safe despite setpoint", {24'b0, out_bus}, {24'b0, SAFE});
         if (f == 1 || f == 2) begin
            ack(1'b1);
            chk("R8 ack refused while raw high", {31'b0, fault_status[1]}, 32'd1);
            ack(1'b0);
            chk("R8 ack accepted", {31'b0, fault_status[1]}, 32'd0);
         end
         cpu_ready = 1'b1;
         inmod_err = 1'b0;
         step(1'b1, 1'b1);
         chk("R5 reentry", {31'b0, run_mode}, 32'd1);
         chk("R2 reentry out", {24'b0, out_bus}, {24'b0, 8'h10 + 8'(f)});
      end

      // R9: tick-count sweep after a heartbeat
      for (int k = 1; k <= 6; k++) begin
         step(1'b1, 1'b0);
         chk("R9 wdog bit", {31'b0, fault_status[2]}, (k > TMO) ? 32'd1 : 32'd0);
         chk("R4 wdog mode", {31'b0, run_mode}, (k <= TMO + 1) ? 32'd1 : 32'd0);
      end
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      chk("R9 recover", {31'b0, run_mode}, 32'd1);

      // R10: disable raised during run mode is ignored
      wdog_disable = 1'b1;
      for (int k = 1; k <= TMO + 2; k++) step(1'b1, 1'b0);
      chk("R10 mask ignored in run", {31'b0, fault_status[2]}, 32'd1);
      chk("R10 exit on expiry", {31'b0, run_mode}, 32'd0);
      idle(1);
      chk("R10 mask taken in safe", {31'b0, fault_status[2]}, 32'd0);
      step(1'b1, 1'b0);
      chk("R10 run with mask", {31'b0, run_mode}, 32'd1);
      wdog_disable = 1'b0;
      for (int k = 1; k <= TMO + 3; k++) step(1'b1, 1'b0);
      chk("R10 clear ignored in run", {31'b0, fault_status[2]}, 32'd0);
      chk("R10 still run", {31'b0, run_mode}, 32'd1);
      inmod_err = 1'b1;
      step(1'b1, 1'b0);
      inmod_err = 1'b0;
      idle(1);
      chk("R10 unmask in safe", {31'b0, fault_status[2]}, 32'd1);
      chk("R11 bit drops", {31'b0, fault_status[3]}, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule